// File: doc/BRIEF.md
# Single-Cycle Three-Format Integer Core

This block is a 32-bit integer processor core. It completes one instruction in every clock cycle, and it has no pipeline. On each cycle it presents the program counter as a word index on an instruction port and takes back a 32-bit instruction word from that port in the same cycle. It splits the word into register, immediate or jump fields. It then reads two of its 32 general registers, computes a result, and writes that result back.

Only load and store instructions touch the data port. They form a byte address by adding a sign-extended 16-bit displacement to a base register. Both memory ports are expected to return read data combinationally, within the same cycle. A separate sequencing unit chooses the next program counter. The choices are the next word in order, a relative branch, an absolute jump with an optional link, and a jump through a register.

Arithmetic takes its operands only from registers, or from one register and the instruction's immediate. A full 32-bit constant is built in two steps: an upper-immediate load followed by an OR-immediate.

Top module: `tfc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. Execution restarts at byte address 0 once reset has been released through the internal two-stage synchroniser.
- R2: Instruction fields are decoded as follows.
  - Field positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump index [25:0].
  - Opcodes: 0 register group, 2 j, 3 jal, 4 beq, 5 bne, 8 addi, 10 slti, 12 andi, 13 ori, 15 lui, 32 lb, 35 lw, 40 sb, 43 sw.
  - Funct codes in the register group: 8 jr, 32 add, 34 sub, 42 slt.
  - Register-group results go to rd. Immediate-format results go to rt.
- R3: add, sub and addi produce the 32-bit two's-complement result, which wraps modulo 2^32.
- R4: slt and slti write 1 when rs is less than the second operand compared as signed values, and 0 otherwise.
- R5: The immediate is extended according to the instruction.
  - addi, slti, lb, lw, sb and sw sign-extend it.
  - andi and ori zero-extend it.
  - lui writes the immediate to bits [31:16] and clears bits [15:0].
- R6: Register 0 always reads as 0, and any write to it is discarded.
- R7: lw reads the full word at rs + sext(imm). sw writes rt to that address with `dmem_be` = 4'b1111.
- R8: Byte accesses use little-endian lanes: the lane is address bits [1:0], and lane k is data bits [8k+7:8k].
  - lb returns the addressed lane, sign-extended to 32 bits.
  - sb drives exactly one enable bit, bit [addr[1:0]], so only that lane changes in memory.
- R9: beq (operands equal) and bne (operands unequal) go to pc+4 + (sext(imm) << 2) when their condition holds, and to pc+4 otherwise.
- R10: j goes to {pc+4 [31:28], index, 2'b00}. jal does the same and also writes pc+4 to register 31. jr goes to the value in rs.
- R11: An opcode or funct not listed in R2 executes as a no-operation. It writes no register, does not write memory, and the PC advances by 4.
- R12: Every instruction that is not a taken redirect advances the PC by 4. `imem_addr` carries PC bits [IMEM_AW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; released through an internal synchroniser |
| imem_addr | output | IMEM_AW | Word index of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word, returned combinationally |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data; for byte stores the byte is replicated on all four lanes |
| dmem_be | output | 4 | Byte-lane enables for a store |
| dmem_we | output | 1 | Store strobe, taken at the rising clock edge |
| dmem_rdata | input | 32 | Word at the aligned address, returned combinationally |

## Verification
The bench sweeps every ordered pair of eight boundary operands through add, sub, slt, addi, slti and andi. The operands include 0, ±1, both signed extremes and values whose low half has bit 15 set. This exposes an unsigned comparison, a sign-extended ori or andi immediate, and a lost carry, each of which would store a wrong word. A directed program then covers the following corner cases:
- Each of the four lb lanes. A wrong lane order or missing sign extension returns the wrong byte value.
- An sb into lane 1 of a known word. A design that wrote the whole word would corrupt the other three bytes.
- A negative displacement. A zero-extended displacement would store far away from the intended address.
- Taken and untaken beq and bne. An inverted condition would leave a marker register at the poison value.
- A jal/jr round trip. A wrong link value would show up in the stored link word.
- Unknown opcode and funct words whose target field points at a live register. A design that did not treat them as no-operations would overwrite that register.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_GROUP = 6'd0;
  localparam logic [5:0] OPC_J     = 6'd2;
  localparam logic [5:0] OPC_JAL   = 6'd3;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] OPC_LB    = 6'd32;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SB    = 6'd40;
  localparam logic [5:0] OPC_SW    = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB} alu_op_e;
  typedef enum logic [1:0] {IMM_SIGN, IMM_ZERO, IMM_UPPER} imm_kind_e;
  typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dst_e;
  typedef enum logic [2:0] {FLOW_SEQ, FLOW_BEQ, FLOW_BNE, FLOW_JUMP, FLOW_JREG} flow_e;

  typedef struct packed {
    alu_op_e   alu_op;
    logic      use_imm;
    imm_kind_e imm_kind;
    dst_e      dst;
    logic      mem_rd;
    logic      mem_wr;
    logic      mem_byte;
    flow_e     flow;
    logic      known;
  } ctrl_t;
endpackage

// File: rtl/tfc_decode.sv
module tfc_decode
  import tfc_pkg::*;
(
  input  logic [XLEN-1:0]   insn,
  output ctrl_t             ctrl,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rt_idx,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [15:0]       imm16,
  output logic [25:0]       jidx
);
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       unused_shamt;

  assign opcode       = insn[31:26];
  assign rs_idx       = insn[25:21];
  assign rt_idx       = insn[20:16];
  assign rd_idx       = insn[15:11];
  assign unused_shamt = ^insn[10:6];
  assign funct        = insn[5:0];
  assign imm16        = insn[15:0];
  assign jidx         = insn[25:0];

  always_comb begin
    ctrl          = '0;
    ctrl.alu_op   = ALU_ADD;
    ctrl.imm_kind = IMM_SIGN;
    ctrl.dst      = DST_NONE;
    ctrl.flow     = FLOW_SEQ;
    case (opcode)
      OPC_GROUP: begin
        case (funct)
          FN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.dst = DST_RD; ctrl.known = 1'b1; end
          FN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.dst = DST_RD; ctrl.known = 1'b1; end
          FN_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.dst = DST_RD; ctrl.known = 1'b1; end
          FN_JR:  begin ctrl.flow = FLOW_JREG; ctrl.known = 1'b1; end
          default: ;
        endcase
      end
      OPC_ADDI: begin ctrl.use_imm = 1'b1; ctrl.dst = DST_RT; ctrl.known = 1'b1; end
      OPC_SLTI: begin ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; ctrl.dst = DST_RT; ctrl.known = 1'b1; end
      OPC_ANDI: begin
        ctrl.use_imm = 1'b1; ctrl.imm_kind = IMM_ZERO; ctrl.alu_op = ALU_AND;
        ctrl.dst = DST_RT; ctrl.known = 1'b1;
      end
      OPC_ORI: begin
        ctrl.use_imm = 1'b1; ctrl.imm_kind = IMM_ZERO; ctrl.alu_op = ALU_OR;
        ctrl.dst = DST_RT; ctrl.known = 1'b1;
      end
      OPC_LUI: begin
        ctrl.use_imm = 1'b1; ctrl.imm_kind = IMM_UPPER; ctrl.alu_op = ALU_PASSB;
        ctrl.dst = DST_RT; ctrl.known = 1'b1;
      end
      OPC_LW: begin ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; ctrl.dst = DST_RT; ctrl.known = 1'b1; end
      OPC_LB: begin
        ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; ctrl.mem_byte = 1'b1;
        ctrl.dst = DST_RT; ctrl.known = 1'b1;
      end
      OPC_SW: begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.known = 1'b1; end
      OPC_SB: begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1; ctrl.known = 1'b1; end
      OPC_BEQ: begin ctrl.flow = FLOW_BEQ; ctrl.known = 1'b1; end
      OPC_BNE: begin ctrl.flow = FLOW_BNE; ctrl.known = 1'b1; end
      OPC_J:   begin ctrl.flow = FLOW_JUMP; ctrl.known = 1'b1; end
      OPC_JAL: begin ctrl.flow = FLOW_JUMP; ctrl.dst = DST_LINK; ctrl.known = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tfc_regfile.sv
module tfc_regfile #(
  parameter int REG_N  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [REG_N*DATA_W-1:0] flat;

  // Entry 0 is hardwired: no storage, writes to it go nowhere (R6)
  assign flat[DATA_W-1:0] = '0;

  for (genvar g = 1; g < REG_N; g++) begin : g_entry
    logic              wen;
    logic [DATA_W-1:0] q;
    assign wen = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (wen) q <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  assign rdata_a = flat[raddr_a*DATA_W +: DATA_W];
  assign rdata_b = flat[raddr_b*DATA_W +: DATA_W];
endmodule

// File: rtl/tfc_alu.sv
module tfc_alu
  import tfc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB:   y = a - b;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end
endmodule

// File: rtl/tfc_seq.sv
module tfc_seq
  import tfc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  flow_e           flow,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [15:0]     imm16,
  input  logic [25:0]     jidx,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_plus4
);
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic            same;

  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {{(XLEN-18){imm16[15]}}, imm16, 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:28], jidx, 2'b00};
  assign same     = (rs_val == rt_val);

  always_comb begin
    case (flow)
      FLOW_BEQ:  pc_d = same ? br_tgt : pc_plus4;
      FLOW_BNE:  pc_d = same ? pc_plus4 : br_tgt;
      FLOW_JUMP: pc_d = jmp_tgt;
      FLOW_JREG: pc_d = rs_val;
      default:   pc_d = pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == FLOW_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R12
  AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == FLOW_BEQ && rs_val != rt_val) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R9
  AST_JUMP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == FLOW_JUMP) |=> (pc_q[27:2] == $past(jidx))); // R10
endmodule

// File: rtl/tfc_core.sv
module tfc_core
  import tfc_pkg::*;
#(
  parameter int               IMEM_AW  = 10,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]    imem_rdata,
  output logic [XLEN-1:0]    dmem_addr,
  output logic [XLEN-1:0]    dmem_wdata,
  output logic [3:0]         dmem_be,
  output logic               dmem_we,
  input  logic [XLEN-1:0]    dmem_rdata
);
  localparam int REG_N = 1 << RIDX_W;
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(REG_N - 1);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, rf_waddr;
  logic [15:0]       imm16;
  logic [25:0]       jidx;
  logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y;
  logic [XLEN-1:0]   pc_q, pc_plus4, rf_wdata, lane_word, load_val;
  logic              rf_we;

  // Reset: asserted asynchronously, released after two clock edges (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  tfc_decode u_decode (
    .insn   (imem_rdata),
    .ctrl   (ctrl),
    .rs_idx (rs_idx),
    .rt_idx (rt_idx),
    .rd_idx (rd_idx),
    .imm16  (imm16),
    .jidx   (jidx)
  );

  tfc_regfile #(.REG_N(REG_N), .DATA_W(XLEN)) u_regfile (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_idx),
    .rdata_a (rs_val),
    .raddr_b (rt_idx),
    .rdata_b (rt_val)
  );

  always_comb begin
    case (ctrl.imm_kind)
      IMM_ZERO:  imm_ext = {16'h0000, imm16};
      IMM_UPPER: imm_ext = {imm16, 16'h0000};
      default:   imm_ext = {{16{imm16[15]}}, imm16};
    endcase
  end
  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  tfc_alu u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  tfc_seq #(.RESET_PC(RESET_PC)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .flow     (ctrl.flow),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .imm16    (imm16),
    .jidx     (jidx),
    .pc_q     (pc_q),
    .pc_plus4 (pc_plus4)
  );

  assign imem_addr = pc_q[IMEM_AW+1:2];

  // Data port: byte address is base plus displacement
  assign dmem_addr  = alu_y;
  assign dmem_we    = ctrl.mem_wr && core_rst_n;
  assign dmem_wdata = ctrl.mem_byte ? {4{rt_val[7:0]}} : rt_val;
  assign dmem_be    = ctrl.mem_byte ? (4'b0001 << dmem_addr[1:0]) : 4'b1111;

  assign lane_word = dmem_rdata >> {dmem_addr[1:0], 3'b000};
  assign load_val  = ctrl.mem_byte ? {{(XLEN-8){lane_word[7]}}, lane_word[7:0]} : dmem_rdata;

  // Write-back selection
  always_comb begin
    case (ctrl.dst)
      DST_RD:   rf_waddr = rd_idx;
      DST_LINK: rf_waddr = LINK_IDX;
      default:  rf_waddr = rt_idx;
    endcase
  end
  assign rf_we    = (ctrl.dst != DST_NONE) && core_rst_n;
  assign rf_wdata = (ctrl.dst == DST_LINK) ? pc_plus4 : (ctrl.mem_rd ? load_val : alu_y);

  AST_BYTE_STORE_LANE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dmem_we && ctrl.mem_byte) |-> ($countones(dmem_be) == 1)); // R8
  AST_WORD_STORE_FULL: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dmem_we && !ctrl.mem_byte) |-> (dmem_be == 4'b1111)); // R7
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!ctrl.known) |-> (!dmem_we && !rf_we)); // R11
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctrl.dst == DST_LINK) |-> (rf_waddr == LINK_IDX && rf_wdata == pc_q + XLEN'(4))); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_n) |-> (!dmem_we)); // R1
endmodule

// File: tb/tfc_core_bench.sv
`timescale 1ns/1ps
module tfc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [64];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tfc_core u_tfc_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_be    (dmem_be),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      for (int k = 0; k < 4; k++)
        if (dmem_be[k]) dmem[dmem_addr[7:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(int op, int widx);
    return {op[5:0], widx[25:0]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;
  endtask

  task automatic start_prog(bit check_reset);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    if (check_reset) begin
      chk("R1 reset imem_addr", {22'd0, imem_addr}, 32'd0);
      chk("R1 reset dmem_we", {31'd0, dmem_we}, 32'd0);
    end
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] mem_word(int byte_addr);
    return dmem[byte_addr / 4];
  endfunction

  initial begin
    logic [31:0] vals [8];
    vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
             32'h1234ABCD, 32'h5, 32'hFFFFFFFB};

    // Noop image: sequential advance and no stores
    clear_imem();
    imem[0] = 32'h0;
    start_prog(1'b1);
    repeat (4) @(negedge clk);
    begin
      logic [9:0] a0;
      a0 = imem_addr;
      @(negedge clk);
      chk("R12 pc advances by one word", {22'd0, imem_addr}, {22'd0, a0 + 10'd1});
      chk("R11 all-zero word stores nothing", {31'd0, dmem_we}, 32'd0);
    end

    // Operand sweep
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        logic [31:0] a, b, bi;
        a = vals[ia];
        b = vals[ib];
        bi = {{16{b[15]}}, b[15:0]};
        clear_imem();
        imem[0]  = enc_i(15, 0, 1, a[31:16]);
        imem[1]  = enc_i(13, 1, 1, a[15:0]);
        imem[2]  = enc_i(15, 0, 2, b[31:16]);
        imem[3]  = enc_i(13, 2, 2, b[15:0]);
        imem[4]  = enc_r(1, 2, 3, 32);
        imem[5]  = enc_r(1, 2, 4, 34);
        imem[6]  = enc_r(1, 2, 5, 42);
        imem[7]  = enc_i(43, 0, 3, 16'd0);
        imem[8]  = enc_i(43, 0, 4, 16'd4);
        imem[9]  = enc_i(43, 0, 5, 16'd8);
        imem[10] = enc_i(8, 1, 6, b[15:0]);
        imem[11] = enc_i(10, 1, 7, b[15:0]);
        imem[12] = enc_i(12, 1, 8, b[15:0]);
        imem[13] = enc_i(43, 0, 6, 16'd12);
        imem[14] = enc_i(43, 0, 7, 16'd16);
        imem[15] = enc_i(43, 0, 8, 16'd20);
        imem[16] = enc_r(1, 2, 0, 32);
        imem[17] = enc_i(43, 0, 0, 16'd24);
        imem[18] = enc_j(2, 18);
        start_prog(1'b0);
        repeat (30) @(negedge clk);
        chk("R3 add", mem_word(0), a + b);
        chk("R3 sub", mem_word(4), a - b);
        chk("R4 slt signed", mem_word(8), ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        chk("R5 addi sign-extended", mem_word(12), a + bi);
        chk("R4 slti signed", mem_word(16), ($signed(a) < $signed(bi)) ? 32'd1 : 32'd0);
        chk("R5 andi zero-extended", mem_word(20), a & {16'h0, b[15:0]});
        chk("R6 register 0 write discarded", mem_word(24), 32'h0);
      end
    end

    // Directed program: memory lanes, branches, jumps, unknown words
    clear_imem();
    imem[0]  = enc_i(15, 0, 1, 16'h80FF);
    imem[1]  = enc_i(13, 1, 1, 16'h7F01);
    imem[2]  = enc_i(43, 0, 1, 16'd32);
    imem[3]  = enc_i(32, 0, 2, 16'd32);
    imem[4]  = enc_i(32, 0, 3, 16'd33);
    imem[5]  = enc_i(32, 0, 4, 16'd34);
    imem[6]  = enc_i(32, 0, 5, 16'd35);
    imem[7]  = enc_i(43, 0, 2, 16'd64);
    imem[8]  = enc_i(43, 0, 3, 16'd68);
    imem[9]  = enc_i(43, 0, 4, 16'd72);
    imem[10] = enc_i(43, 0, 5, 16'd76);
    imem[11] = enc_i(15, 0, 6, 16'h1122);
    imem[12] = enc_i(13, 6, 6, 16'h3344);
    imem[13] = enc_i(43, 0, 6, 16'd40);
    imem[14] = enc_i(8, 0, 7, 16'h00AB);
    imem[15] = enc_i(40, 0, 7, 16'd41);
    imem[16] = enc_i(35, 0, 8, 16'd40);
    imem[17] = enc_i(43, 0, 8, 16'd80);
    imem[18] = enc_i(8, 0, 9, 16'd100);
    imem[19] = enc_i(43, 9, 6, 16'hFFFC);
    imem[20] = enc_i(4, 2, 3, 16'd1);
    imem[21] = enc_i(8, 0, 10, 16'd1);
    imem[22] = enc_i(4, 2, 2, 16'd1);
    imem[23] = enc_i(8, 0, 10, 16'd99);
    imem[24] = enc_i(5, 2, 2, 16'd1);
    imem[25] = enc_i(8, 0, 11, 16'd7);
    imem[26] = enc_i(5, 2, 3, 16'd1);
    imem[27] = enc_i(8, 0, 11, 16'd99);
    imem[28] = enc_i(43, 0, 10, 16'd84);
    imem[29] = enc_i(43, 0, 11, 16'd88);
    imem[30] = enc_j(3, 40);
    imem[31] = enc_i(43, 0, 31, 16'd92);
    imem[32] = enc_i(8, 0, 12, 16'hFFFE);
    imem[33] = enc_i(43, 0, 12, 16'd100);
    imem[34] = enc_i(63, 0, 12, 16'h5555);
    imem[35] = enc_r(1, 2, 12, 63);
    imem[36] = enc_i(43, 0, 12, 16'd104);
    imem[37] = enc_j(2, 60);
    imem[38] = enc_i(43, 0, 1, 16'd112);
    imem[40] = enc_i(8, 0, 13, 16'h0055);
    imem[41] = enc_i(43, 0, 13, 16'd108);
    imem[42] = enc_r(31, 0, 0, 8);
    imem[60] = enc_j(2, 60);
    start_prog(1'b1);
    repeat (70) @(negedge clk);
    chk("R7 sw full word", mem_word(32), 32'h80FF7F01);
    chk("R8 lb lane 0", mem_word(64), 32'h00000001);
    chk("R8 lb lane 1", mem_word(68), 32'h0000007F);
    chk("R8 lb lane 2 sign", mem_word(72), 32'hFFFFFFFF);
    chk("R8 lb lane 3 sign", mem_word(76), 32'hFFFFFF80);
    chk("R8 sb one lane", mem_word(40), 32'h1122AB44);
    chk("R7 lw after sb", mem_word(80), 32'h1122AB44);
    chk("R7 negative displacement", mem_word(96), 32'h11223344);
    chk("R9 beq/beq fallthrough and taken", mem_word(84), 32'd1);
    chk("R9 bne fallthrough and taken", mem_word(88), 32'd7);
    chk("R10 jal link value", mem_word(92), 32'd124);
    chk("R10 jal target reached", mem_word(108), 32'h55);
    chk("R5 addi negative", mem_word(100), 32'hFFFFFFFE);
    chk("R11 unknown opcode and funct no-op", mem_word(104), 32'hFFFFFFFE);
    chk("R10 j skips next word", mem_word(112), 32'h0);
    chk("R10 j self loop index", {22'd0, imem_addr}, 32'd60);
    chk("R2 unknown words wrote no memory", mem_word(116), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule